// File: doc/BRIEF.md
# Nine-Bit Serial Panel Configuration Sequencer

This block brings a small LCD controller up and shuts it down again by playing a fixed script of register writes over a write-only three-wire serial link. A one-cycle `start_i` pulse plays the bring-up script. A one-cycle `stop_i` pulse plays the shutdown script. Every step of a script is one transaction: a command word, followed by zero, one or two data words, all inside a single low period of chip select.

Each word on the link is nine bits long and is sent most significant bit first. The top bit tells the panel whether the word is a command or a data byte. The script lives in an internal constant table. Each table entry carries an opcode, an argument count, a 16-bit value and a pause flag. A flagged entry is followed by a pause of `PAUSE_US` microseconds, timed by a counter that is sized from `CLK_FREQ_HZ`.

The host starts a script and then watches `busy_o`, `done_o` and the sticky `err_o`.

Top module: `panel_cfg_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `cs_n_o`=1, `sck_o`=1, `busy_o`=0, `done_o`=0 and `err_o`=0. A reset also clears `err_o`.
- R2: Every transaction is a whole number of 9-bit words, sent MSB first. Bit 8 is 0 for the command word and 1 for each data word, and bits 7:0 carry the byte. The clock idles high whenever chip select is high. `mosi_o` changes only while `sck_o` is low, so the receiver samples it on the rising edge.
- R3: A two-byte argument is sent as two data words, the upper byte before the lower byte.
- R4: `cs_n_o` stays low from the first bit of the command word to the last bit of the last data word. Between transactions it stays high for at least `2*SCK_HALF` clock cycles.
- R5: The bring-up script opens with three transactions that each carry only command 0x00. Each of them is followed by a gap of at least `CLK_FREQ_HZ/1e6*PAUSE_US` cycles before the next chip-select fall.
- R6: Transactions 3 to 8 of bring-up are, in order: 0xB0←0x17, 0xBC←0x80, 0x3B←0x00, 0xB0←0x16, 0xB8←0xFFF9 (two bytes), then the bare command 0x11. After an unflagged step the next transaction starts well within one pause.
- R7: Bring-up is 44 transactions in all and ends with the bare command 0x29. Its register block includes 0xBA←0x01, 0x3A←0x60, 0xBD←0x04, 0xC0, 0xC1 and 0xC2←0x11, 0xC3←0x2040, 0xC4←0x60C0 and 0xD3←0x0D0E.
- R8: Shutdown is exactly four transactions: bare command 0x28, 0xB8←0x8002, bare command 0x10, then 0xB0←0x00.
- R9: `busy_o` rises and `done_o` clears on the clock edge that accepts a request. After the last transaction `busy_o` falls and `done_o` rises together, and the two are never high at the same time.
- R10: A `start_i` or `stop_i` pulse seen while `busy_o`=1 changes neither the running script nor its length, and it sets `err_o`. Once set, `err_o` stays set until reset.
- R11: `start_i` and `stop_i` high in the same idle cycle start no script, and they set `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run the bring-up script |
| stop_i | input | 1 | Request to run the shutdown script |
| busy_o | output | 1 | A script is running |
| done_o | output | 1 | The last script finished |
| err_o | output | 1 | Sticky flag for a rejected request |
| sck_o | output | 1 | Serial clock, idles high |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |

## Verification
The assertions assume a few things about the inputs. `start_i` and `stop_i` are synchronous to `clk`. Each request is a single-cycle pulse. Reset is the only way to clear the error flag.

The busy-request property also assumes that a request coming in mid-script must leave the table pointer untouched, except on the step that advances it. The bench keeps to these assumptions. It drives every request as a one-cycle pulse on the falling clock edge. Its late requests arrive only after several transactions have gone out. Between scenarios it re-applies reset rather than expecting the error flag to clear in any other way.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;
   localparam int ARG_W     = 8;
   localparam int MAX_ARGS  = 2;
   localparam int WORD_W    = ARG_W + 1;
   localparam int VAL_W     = ARG_W * MAX_ARGS;
   localparam int FRAME_W   = WORD_W * (MAX_ARGS + 1);
   localparam int CNT_W     = $clog2(MAX_ARGS + 1);
   localparam int BIT_W     = $clog2(FRAME_W + 1);
   localparam int ROM_DEPTH = 48;
   localparam int IDX_W     = $clog2(ROM_DEPTH);
   localparam int UP_FIRST  = 0;
   localparam int UP_LAST   = 43;
   localparam int DN_FIRST  = 44;
   localparam int DN_LAST   = 47;

   typedef struct packed {
      logic [ARG_W-1:0] op;
      logic [CNT_W-1:0] nargs;
      logic [VAL_W-1:0] val;
      logic             pause;
   } step_t;

   typedef enum logic [2:0] {
      SR_IDLE, SR_LEAD, SR_LOW, SR_HIGH, SR_GAP
   } ser_st_t;

   typedef enum logic [2:0] {
      T_IDLE, T_FETCH, T_XFER, T_PAUSE, T_STEP
   } seq_st_t;

   function automatic step_t mk_step(input logic [ARG_W-1:0] op, input int n,
                                     input logic [VAL_W-1:0] v, input logic p);
      step_t s;
      s.op    = op;
      s.nargs = CNT_W'(n);
      s.val   = v;
      s.pause = p;
      return s;
   endfunction
endpackage

// File: rtl/panel_cfg_rom.sv
module panel_cfg_rom
   import panel_cfg_pkg::*;
(
   input  logic [IDX_W-1:0] idx_i,
   output step_t            step_o
);
   always_comb begin
      case (idx_i)
         6'd0:  step_o = mk_step(8'h00, 0, 16'h0000, 1'b1);
         6'd1:  step_o = mk_step(8'h00, 0, 16'h0000, 1'b1);
         6'd2:  step_o = mk_step(8'h00, 0, 16'h0000, 1'b1);
         6'd3:  step_o = mk_step(8'hB0, 1, 16'h0017, 1'b0);
         6'd4:  step_o = mk_step(8'hBC, 1, 16'h0080, 1'b0);
         6'd5:  step_o = mk_step(8'h3B, 1, 16'h0000, 1'b0);
         6'd6:  step_o = mk_step(8'hB0, 1, 16'h0016, 1'b0);
         6'd7:  step_o = mk_step(8'hB8, 2, 16'hFFF9, 1'b0);
         6'd8:  step_o = mk_step(8'h11, 0, 16'h0000, 1'b0);
         6'd9:  step_o = mk_step(8'hBA, 1, 16'h0001, 1'b0);
         6'd10: step_o = mk_step(8'hBB, 1, 16'h0000, 1'b0);
         6'd11: step_o = mk_step(8'h3A, 1, 16'h0060, 1'b0);
         6'd12: step_o = mk_step(8'hBF, 1, 16'h0010, 1'b0);
         6'd13: step_o = mk_step(8'hB1, 1, 16'h0056, 1'b0);
         6'd14: step_o = mk_step(8'hB2, 1, 16'h0033, 1'b0);
         6'd15: step_o = mk_step(8'hB3, 1, 16'h0011, 1'b0);
         6'd16: step_o = mk_step(8'hB3, 1, 16'h0011, 1'b0);
         6'd17: step_o = mk_step(8'hB4, 1, 16'h0002, 1'b0);
         6'd18: step_o = mk_step(8'hB5, 1, 16'h002B, 1'b0);
         6'd19: step_o = mk_step(8'hB6, 1, 16'h0040, 1'b0);
         6'd20: step_o = mk_step(8'hB7, 1, 16'h0003, 1'b0);
         6'd21: step_o = mk_step(8'hB9, 1, 16'h0004, 1'b0);
         6'd22: step_o = mk_step(8'hBD, 1, 16'h0004, 1'b0);
         6'd23: step_o = mk_step(8'hBE, 1, 16'h0000, 1'b0);
         6'd24: step_o = mk_step(8'hC0, 1, 16'h0011, 1'b0);
         6'd25: step_o = mk_step(8'hC1, 1, 16'h0011, 1'b0);
         6'd26: step_o = mk_step(8'hC2, 1, 16'h0011, 1'b0);
         6'd27: step_o = mk_step(8'hC3, 2, 16'h2040, 1'b0);
         6'd28: step_o = mk_step(8'hC4, 2, 16'h60C0, 1'b0);
         6'd29: step_o = mk_step(8'hC5, 2, 16'h1020, 1'b0);
         6'd30: step_o = mk_step(8'hC6, 2, 16'h60C0, 1'b0);
         6'd31: step_o = mk_step(8'hC7, 2, 16'h5533, 1'b0);
         6'd32: step_o = mk_step(8'hC8, 1, 16'h0000, 1'b0);
         6'd33: step_o = mk_step(8'hC9, 1, 16'h0000, 1'b0);
         6'd34: step_o = mk_step(8'hCA, 1, 16'h0000, 1'b0);
         6'd35: step_o = mk_step(8'hEC, 2, 16'h01F0, 1'b0);
         6'd36: step_o = mk_step(8'hCF, 1, 16'h0002, 1'b0);
         6'd37: step_o = mk_step(8'hD0, 2, 16'h0804, 1'b0);
         6'd38: step_o = mk_step(8'hD1, 1, 16'h0001, 1'b0);
         6'd39: step_o = mk_step(8'hD2, 2, 16'h0000, 1'b0);
         6'd40: step_o = mk_step(8'hD3, 2, 16'h0D0E, 1'b0);
         6'd41: step_o = mk_step(8'hD4, 2, 16'h11A4, 1'b0);
         6'd42: step_o = mk_step(8'hD5, 1, 16'h000E, 1'b0);
         6'd43: step_o = mk_step(8'h29, 0, 16'h0000, 1'b0);
         6'd44: step_o = mk_step(8'h28, 0, 16'h0000, 1'b0);
         6'd45: step_o = mk_step(8'hB8, 2, 16'h8002, 1'b0);
         6'd46: step_o = mk_step(8'h10, 0, 16'h0000, 1'b0);
         6'd47: step_o = mk_step(8'hB0, 1, 16'h0000, 1'b0);
         default: step_o = mk_step(8'h00, 0, 16'h0000, 1'b0);
      endcase
   end
endmodule

// File: rtl/panel_cfg_timer.sv
module panel_cfg_timer #(
   parameter int TICKS = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o,
   output logic fire_o
);
   localparam int CW = $clog2(TICKS + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (load_i)          cnt <= CW'(TICKS);
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign busy_o = (cnt != '0);
   assign fire_o = (cnt == CW'(1));

   // R5: the pause ends right after the fire cycle
   p_fire_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !load_i) |=> !busy_o);
endmodule

// File: rtl/panel_cfg_ser9.sv
module panel_cfg_ser9
   import panel_cfg_pkg::*;
#(
   parameter int SCK_HALF = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [BIT_W-1:0]   nbits_i,
   output logic               idle_o,
   output logic               done_o,
   output logic               sck_o,
   output logic               cs_n_o,
   output logic               mosi_o
);
   localparam int GAP_CYC = 2 * SCK_HALF;
   localparam int HW      = $clog2(GAP_CYC + 1);

   ser_st_t            st;
   logic [HW-1:0]      hc;
   logic [BIT_W-1:0]   left;
   logic [FRAME_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SR_IDLE;
         hc     <= '0;
         left   <= '0;
         sh     <= '0;
         sck_o  <= 1'b1;
         cs_n_o <= 1'b1;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st)
            SR_IDLE: if (go_i) begin
               sh     <= frame_i;
               left   <= nbits_i - 1'b1;
               cs_n_o <= 1'b0;
               hc     <= HW'(SCK_HALF - 1);
               st     <= SR_LEAD;
            end
            SR_LEAD: if (hc == '0) begin
               sck_o <= 1'b0;
               hc    <= HW'(SCK_HALF - 1);
               st    <= SR_LOW;
            end else hc <= hc - 1'b1;
            SR_LOW: if (hc == '0) begin
               sck_o <= 1'b1;
               hc    <= HW'(SCK_HALF - 1);
               st    <= SR_HIGH;
            end else hc <= hc - 1'b1;
            SR_HIGH: if (hc == '0) begin
               if (left == '0) begin
                  cs_n_o <= 1'b1;
                  hc     <= HW'(GAP_CYC - 1);
                  st     <= SR_GAP;
               end else begin
                  sck_o <= 1'b0;
                  sh    <= sh << 1;
                  left  <= left - 1'b1;
                  hc    <= HW'(SCK_HALF - 1);
                  st    <= SR_LOW;
               end
            end else hc <= hc - 1'b1;
            SR_GAP: if (hc == '0) begin
               done_o <= 1'b1;
               st     <= SR_IDLE;
            end else hc <= hc - 1'b1;
            default: st <= SR_IDLE;
         endcase
      end
   end

   assign mosi_o = sh[FRAME_W-1];
   assign idle_o = (st == SR_IDLE);

   // cycles with chip select high, saturating; starts saturated after reset
   logic [HW-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hi_cnt <= HW'(GAP_CYC);
      else if (!cs_n_o)         hi_cnt <= '0;
      else if (hi_cnt < HW'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
   end

   p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sck_o);

   p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && $past(!cs_n_o) && sck_o && $past(sck_o)) |-> $stable(mosi_o));

   p_cs_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (hi_cnt >= HW'(GAP_CYC)));
endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
   import panel_cfg_pkg::*;
#(
   parameter int CLK_FREQ_HZ = 50_000_000,
   parameter int PAUSE_US    = 1000,
   parameter int SCK_HALF    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   output logic busy_o,
   output logic done_o,
   output logic err_o,
   output logic sck_o,
   output logic cs_n_o,
   output logic mosi_o
);
   localparam int TICKS = (CLK_FREQ_HZ / 1_000_000) * PAUSE_US;

   if (CLK_FREQ_HZ < 1_000_000) begin : g_chk_clk
      $error("CLK_FREQ_HZ below 1 MHz cannot time microseconds");
   end
   if (SCK_HALF < 1) begin : g_chk_half
      $error("SCK_HALF must be at least 1");
   end
   if (PAUSE_US < 1) begin : g_chk_pause
      $error("PAUSE_US must be at least 1");
   end

   seq_st_t          st;
   logic [IDX_W-1:0] ptr, last;
   step_t            step;
   logic             ser_go, ser_idle, ser_done;
   logic             tmr_load, tmr_busy, tmr_fire;

   panel_cfg_rom u_rom (.idx_i(ptr), .step_o(step));

   // frame packing: command word on top, argument words below, upper byte first
   logic [FRAME_W-1:0] frame;
   logic [BIT_W-1:0]   nbits;
   assign frame[FRAME_W-1 -: WORD_W] = {1'b0, step.op};

   for (genvar g = 0; g < MAX_ARGS; g++) begin : g_arg
      logic [ARG_W-1:0] arg_b;
      always_comb begin
         int k;
         k = int'(step.nargs) - 1 - g;
         if (k >= 0 && k < MAX_ARGS) arg_b = step.val[k*ARG_W +: ARG_W];
         else                        arg_b = '0;
      end
      assign frame[FRAME_W-1-WORD_W*(g+1) -: WORD_W] = {1'b1, arg_b};
   end

   assign nbits = BIT_W'(WORD_W * (int'(step.nargs) + 1));

   assign ser_go   = (st == T_FETCH);
   assign tmr_load = (st == T_XFER) && ser_done && step.pause;

   panel_cfg_ser9 #(.SCK_HALF(SCK_HALF)) u_ser (
      .clk(clk), .rst_n(rst_n), .go_i(ser_go), .frame_i(frame), .nbits_i(nbits),
      .idle_o(ser_idle), .done_o(ser_done),
      .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o));

   panel_cfg_timer #(.TICKS(TICKS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
      .busy_o(tmr_busy), .fire_o(tmr_fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= T_IDLE;
         ptr    <= '0;
         last   <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
      end else begin
         case (st)
            T_IDLE: begin
               if (start_i && !stop_i) begin
                  ptr    <= IDX_W'(UP_FIRST);
                  last   <= IDX_W'(UP_LAST);
                  busy_o <= 1'b1;
                  done_o <= 1'b0;
                  st     <= T_FETCH;
               end else if (stop_i && !start_i) begin
                  ptr    <= IDX_W'(DN_FIRST);
                  last   <= IDX_W'(DN_LAST);
                  busy_o <= 1'b1;
                  done_o <= 1'b0;
                  st     <= T_FETCH;
               end
            end
            T_FETCH: st <= T_XFER;
            T_XFER:  if (ser_done) st <= step.pause ? T_PAUSE : T_STEP;
            T_PAUSE: if (tmr_fire) st <= T_STEP;
            T_STEP: begin
               if (ptr == last) begin
                  busy_o <= 1'b0;
                  done_o <= 1'b1;
                  st     <= T_IDLE;
               end else begin
                  ptr <= ptr + 1'b1;
                  st  <= T_FETCH;
               end
            end
            default: st <= T_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_o <= 1'b0;
      else if ((start_i && stop_i) || ((start_i || stop_i) && st != T_IDLE))
         err_o <= 1'b1;
   end

   p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o));

   p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && st != T_STEP && (start_i || stop_i)) |=> (busy_o && $stable(ptr) && $stable(last)));

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   p_both_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && stop_i) |=> (!busy_o && err_o));

   p_pause_timed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == T_PAUSE) |-> tmr_busy);

   p_go_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ser_go |-> ser_idle);
endmodule

// File: tb/panel_cfg_seq_tb.sv
`timescale 1ns/1ps
module panel_cfg_seq_tb;
   localparam int CLK_HZ = 4_000_000;
   localparam int P_US   = 1000;
   localparam int HALF   = 2;
   localparam int TICKS  = (CLK_HZ / 1_000_000) * P_US;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, stop_i = 1'b0;
   logic busy_o, done_o, err_o, sck_o, cs_n_o, mosi_o;

   always #2 clk = ~clk;

   panel_cfg_seq #(.CLK_FREQ_HZ(CLK_HZ), .PAUSE_US(P_US), .SCK_HALF(HALF)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o));

   int checks = 0, errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc++;

   // link monitor
   int          ntx = 0, bitn = 0, nw = 0, bad_frames = 0;
   logic [8:0]  sreg = '0;
   logic [8:0]  wb [3];
   logic [31:0] tx_pk [64];
   int          fall_t [64];
   int          rise_t [64];

   always @(negedge cs_n_o) begin
      bitn = 0; nw = 0;
      for (int i = 0; i < 3; i++) wb[i] = '0;
      if (ntx < 64) fall_t[ntx] = cyc;
   end
   always @(posedge sck_o) if (cs_n_o === 1'b0) begin
      sreg = {sreg[7:0], mosi_o};
      bitn++;
      if (bitn % 9 == 0) begin
         if (nw < 3) wb[nw] = sreg;
         nw++;
      end
   end
   always @(posedge cs_n_o) if (bitn > 0) begin
      if (bitn % 9 != 0 || nw > 3) bad_frames++;
      if (ntx < 64) begin
         tx_pk[ntx]  = {5'(nw), wb[0], wb[1], wb[2]};
         rise_t[ntx] = cyc;
      end
      ntx++;
      bitn = 0;
   end

   function automatic logic [31:0] pk(input int n, input logic [8:0] a, b, c);
      return {5'(n), a, b, c};
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input longint act, input longint exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic tx_is(input int i, input logic [31:0] exp, input string tag);
      chk_eq(tag, (i < ntx) ? longint'(tx_pk[i]) : -1, exp);
   endtask

   task automatic find_op(input logic [7:0] op, input logic [31:0] exp, input string tag);
      longint got = -1;
      for (int i = ntx - 1; i >= 0; i--)
         if (i < 64 && tx_pk[i][26:18] == {1'b0, op}) got = tx_pk[i];
      chk_eq(tag, got, exp);
   endtask

   task automatic pulse(input bit s, input bit p);
      @(negedge clk); start_i = s; stop_i = p;
      @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 60000 && done_o !== 1'b1; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
      repeat (4) @(negedge clk);
      chk_eq("R1 cs_n in reset", cs_n_o, 1);
      chk_eq("R1 sck in reset", sck_o, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1 busy after reset", busy_o, 0);
      chk_eq("R1 done after reset", done_o, 0);
      chk_eq("R1 err after reset", err_o, 0);
      chk_eq("R1 cs_n after reset", cs_n_o, 1);
   endtask

   task automatic t_bringup();
      ntx = 0; bad_frames = 0;
      pulse(1'b1, 1'b0);
      chk_eq("R9 busy on accept", busy_o, 1);
      chk_eq("R9 done cleared on accept", done_o, 0);
      wait_done();
      chk_eq("R9 done at end", done_o, 1);
      chk_eq("R9 busy at end", busy_o, 0);
      chk_eq("R7 bring-up length", ntx, 44);
      chk_eq("R2 whole 9-bit frames", bad_frames, 0);
      for (int i = 0; i < 3; i++) begin
         tx_is(i, pk(1, 9'h000, 9'h0, 9'h0), "R5 bare command 0x00");
         chk(fall_t[i+1] - rise_t[i] >= TICKS, "R5 pause after 0x00",
             fall_t[i+1] - rise_t[i], TICKS);
      end
      tx_is(3, pk(2, 9'h0B0, 9'h117, 9'h0), "R6 0xB0<-0x17");
      tx_is(4, pk(2, 9'h0BC, 9'h180, 9'h0), "R6 0xBC<-0x80");
      tx_is(5, pk(2, 9'h03B, 9'h100, 9'h0), "R6 0x3B<-0x00");
      tx_is(6, pk(2, 9'h0B0, 9'h116, 9'h0), "R6 0xB0<-0x16");
      tx_is(7, pk(3, 9'h0B8, 9'h1FF, 9'h1F9), "R3 R6 0xB8<-0xFFF9 upper first");
      tx_is(8, pk(1, 9'h011, 9'h0, 9'h0), "R6 bare 0x11");
      chk(fall_t[4] - rise_t[3] < TICKS, "R6 no pause after unflagged step",
          fall_t[4] - rise_t[3], TICKS);
      for (int i = 0; i < 43; i++)
         chk(fall_t[i+1] - rise_t[i] >= 2*HALF, "R4 chip-select gap",
             fall_t[i+1] - rise_t[i], 2*HALF);
      find_op(8'hBA, pk(2, 9'h0BA, 9'h101, 9'h0), "R7 0xBA<-0x01");
      find_op(8'h3A, pk(2, 9'h03A, 9'h160, 9'h0), "R7 0x3A<-0x60");
      find_op(8'hBD, pk(2, 9'h0BD, 9'h104, 9'h0), "R7 0xBD<-0x04");
      find_op(8'hC0, pk(2, 9'h0C0, 9'h111, 9'h0), "R7 0xC0<-0x11");
      find_op(8'hC1, pk(2, 9'h0C1, 9'h111, 9'h0), "R7 0xC1<-0x11");
      find_op(8'hC2, pk(2, 9'h0C2, 9'h111, 9'h0), "R7 0xC2<-0x11");
      find_op(8'hC3, pk(3, 9'h0C3, 9'h120, 9'h140), "R3 R7 0xC3<-0x2040");
      find_op(8'hC4, pk(3, 9'h0C4, 9'h160, 9'h1C0), "R7 0xC4<-0x60C0");
      find_op(8'hD3, pk(3, 9'h0D3, 9'h10D, 9'h10E), "R7 0xD3<-0x0D0E");
      tx_is(43, pk(1, 9'h029, 9'h0, 9'h0), "R7 final bare 0x29");
   endtask

   task automatic t_shutdown();
      ntx = 0; bad_frames = 0;
      pulse(1'b0, 1'b1);
      chk_eq("R9 busy on shutdown accept", busy_o, 1);
      chk_eq("R9 done cleared on shutdown", done_o, 0);
      wait_done();
      chk_eq("R8 shutdown length", ntx, 4);
      chk_eq("R2 whole frames in shutdown", bad_frames, 0);
      tx_is(0, pk(1, 9'h028, 9'h0, 9'h0), "R8 bare 0x28");
      tx_is(1, pk(3, 9'h0B8, 9'h180, 9'h102), "R3 R8 0xB8<-0x8002");
      tx_is(2, pk(1, 9'h010, 9'h0, 9'h0), "R8 bare 0x10");
      tx_is(3, pk(2, 9'h0B0, 9'h100, 9'h0), "R8 0xB0<-0x00");
   endtask

   task automatic t_busy_requests();
      ntx = 0;
      pulse(1'b1, 1'b0);
      for (int i = 0; i < 20000 && ntx < 5; i++) @(negedge clk);
      pulse(1'b0, 1'b1);
      repeat (3) @(negedge clk);
      pulse(1'b1, 1'b0);
      chk_eq("R10 still busy after late request", busy_o, 1);
      wait_done();
      chk_eq("R10 script length unchanged", ntx, 44);
      tx_is(43, pk(1, 9'h029, 9'h0, 9'h0), "R10 script not switched");
      chk_eq("R10 err set", err_o, 1);
      repeat (300) @(negedge clk);
      chk_eq("R10 no extra transactions", ntx, 44);
      chk_eq("R10 err sticky", err_o, 1);
   endtask

   task automatic t_both();
      ntx = 0;
      pulse(1'b1, 1'b1);
      chk_eq("R11 not busy", busy_o, 0);
      repeat (300) @(negedge clk);
      chk_eq("R11 no transactions", ntx, 0);
      chk_eq("R11 err set", err_o, 1);
      chk_eq("R11 cs_n idle", cs_n_o, 1);
   endtask

   initial begin
      #(200000 * 4);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_bringup();
      t_shutdown();
      t_reset();
      t_busy_requests();
      t_reset();
      t_both();
      t_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule